// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits on the device side of an SDRAM and produces the column address for every beat of a read or write burst. When a column command is accepted, the load strobe captures the starting column together with the burst mode: burst length, ordering and the single-beat-write option. From the next clock on, the block presents one column address per cycle until the burst ends. It raises a done flag while the final beat's address is on the output.

Two orderings are supported. Sequential order counts upward through the low bits of the column and wraps inside the block of columns aligned to the burst length. Interleaved order XORs the beat index into those same low bits. In both orders the column bits above the burst block stay fixed. In single-write mode a write burst is always one beat long, and a read keeps the programmed length. A new load arriving during a burst cuts that burst short and starts the new one on the following cycle.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, valid_o and done_o are 0 and stay 0 until the first load.
- R2: On the cycle after a clock edge with load_i high, valid_o is 1 and col_o equals start_col_i as sampled at that edge.
- R3: Burst length code bl_code_i values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. There is one beat per cycle, and valid_o drops on the cycle after the last beat unless a new load arrives.
- R4: With interleave_i = 0, beat i has low log2(BL) column bits equal to (start low bits + i) mod BL. The bits above them are equal to the start column's upper bits.
- R5: With interleave_i = 1, beat i has low log2(BL) column bits equal to the start low bits XOR i. The upper bits are unchanged.
- R6: When single_wr_i = 1 and is_write_i = 1 at load, the burst is one beat long. When single_wr_i = 1 and is_write_i = 0, the burst keeps the length given by bl_code_i.
- R7: done_o is 1 exactly on the cycle that presents the final beat of a burst, and is 0 otherwise.
- R8: A load during an active burst ends it. The next cycle presents beat 0 of the new burst.
- R9: bl_code_i, interleave_i, single_wr_i, is_write_i and start_col_i are sampled only at load. Changing them during a burst does not alter its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Column command accepted; captures the start column and the mode |
| start_col_i | input | 9 | Starting column of the burst |
| bl_code_i | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| interleave_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| single_wr_i | input | 1 | Single-beat write mode |
| is_write_i | input | 1 | The accepted command is a write |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| done_o | output | 1 | The current beat is the last of the burst |

## Verification
Beat 0 appears one cycle after the edge that samples load_i. Each further beat follows one cycle later, and valid_o falls on the cycle after the beat flagged by done_o. The driver pushes the expected address and done flag for each beat into a queue in the order they are due. The monitor samples on the falling edge, pops one entry per valid cycle, and reports any valid cycle that has no queued entry. For bursts cut short, the driver queues only the beats that will appear before the restart. The driver changes the mode inputs right after each load, so any late sampling shows up as a wrong address or a wrong length.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec #(
  parameter int BEAT_W = 3,
  localparam int CODE_W = $clog2(BEAT_W + 1)
) (
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              single_wr_i,
  input  logic              is_write_i,
  output logic [BEAT_W-1:0] last_idx_o
);
  logic [BEAT_W-1:0] mask;
  logic              force_one;

  // mask bit b is set when the burst spans more than 2**b beats
  for (genvar b = 0; b < BEAT_W; b++) begin : g_mask
    assign mask[b] = (bl_code_i > CODE_W'(b));
  end

  assign force_one  = single_wr_i & is_write_i;
  assign last_idx_o = force_one ? '0 : mask;
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] last_idx_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [BEAT_W-1:0] mask_o
);
  logic              valid_q;
  logic [BEAT_W-1:0] beat_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      last_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
      last_q  <= last_idx_i;
    end else if (valid_q) begin
      if (beat_q == last_q) valid_q <= 1'b0;
      else                  beat_q  <= beat_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = valid_q && (beat_q == last_q);
  assign beat_o  = beat_q;
  assign mask_o  = last_q;

  // R7
  done_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
  // R3
  end_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> !valid_o);
  // R1
  idle_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> (!valid_o && !done_o));
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BEAT_W-1:0] mask_i,
  input  burst_ord_e        order_i,
  output logic [COL_W-1:0]  col_o
);
  localparam int UP_W = COL_W - BEAT_W;

  logic [BEAT_W-1:0] low_seq, low_ilv, low_sel;

  always_comb begin
    low_seq = base_i[BEAT_W-1:0] + beat_i;
    low_ilv = base_i[BEAT_W-1:0] ^ beat_i;
    low_sel = (order_i == ORD_ILV) ? low_ilv : low_seq;
    // bits outside the burst block come from the start column
    col_o   = {base_i[COL_W-1:BEAT_W],
               (base_i[BEAT_W-1:0] & ~mask_i) | (low_sel & mask_i)};
  end

  if (UP_W < 1) begin : g_bad_width
    initial $error("COL_W must exceed BEAT_W");
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3,
  localparam int CODE_W = $clog2(BEAT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              interleave_i,
  input  logic              single_wr_i,
  input  logic              is_write_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              done_o
);
  logic [COL_W-1:0]  base_q;
  burst_ord_e        order_q;
  logic [BEAT_W-1:0] last_idx, beat, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (load_i) begin
      base_q  <= start_col_i;
      order_q <= interleave_i ? ORD_ILV : ORD_SEQ;
    end
  end

  colgen_len_dec #(.BEAT_W(BEAT_W)) i_len_dec (
    .bl_code_i  (bl_code_i),
    .single_wr_i(single_wr_i),
    .is_write_i (is_write_i),
    .last_idx_o (last_idx)
  );

  colgen_beat_ctr #(.BEAT_W(BEAT_W)) i_beat_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .last_idx_i(last_idx),
    .valid_o   (valid_o),
    .done_o    (done_o),
    .beat_o    (beat),
    .mask_o    (mask)
  );

  colgen_addr #(.COL_W(COL_W), .BEAT_W(BEAT_W)) i_addr (
    .base_i (base_q),
    .beat_i (beat),
    .mask_i (mask),
    .order_i(order_q),
    .col_o  (col_o)
  );

  // R2
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (valid_o && col_o == $past(start_col_i)));
  // R4
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o && !load_i) |=>
      (col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W])));
  // R6
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && single_wr_i && is_write_i) |=> done_o);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && load_i) |=> (valid_o && col_o == $past(start_col_i)));
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [8:0] col;
    logic       done;
    string      req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       load = 1'b0, ilv = 1'b0, sw = 1'b0, wr = 1'b0;
  logic [8:0] start = '0;
  logic [1:0] code = '0;
  logic [8:0] col;
  logic       valid, done;

  int   checks = 0, errors = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_col_i(start),
    .bl_code_i(code), .interleave_i(ilv), .single_wr_i(sw), .is_write_i(wr),
    .col_o(col), .valid_o(valid), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one burst; keep = beats shown before the next load (0 = all)
  task automatic issue(input logic [8:0] s, input logic [1:0] c, input logic il,
                       input logic sgl, input logic w, input int keep, input string req);
    int len, n, mask;
    len  = (sgl && w) ? 1 : (1 << c);
    n    = (keep == 0 || keep > len) ? len : keep;
    mask = len - 1;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int   low;
      low    = il ? ((int'(s) ^ i) & mask) : ((int'(s) + i) & mask);
      e.col  = 9'((int'(s) & ~mask) | low);
      e.done = (i == len - 1);
      e.req  = req;
      sb.push_back(e);
    end
    start = s; code = c; ilv = il; sw = sgl; wr = w; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    // R9: scramble mode inputs mid-burst
    start = ~s; code = ~c; ilv = ~il; sw = ~sgl; wr = ~w;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idle_gap(input int cyc);
    repeat (cyc) begin
      @(negedge clk);
      chk(!valid && !done, "R3 idle after burst", int'(valid), 0);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3 unexpected beat", int'(col), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(col == e.col, {e.req, " col"}, int'(col), int'(e.col));
        chk(done == e.done, {"R7 done / ", e.req}, int'(done), int'(e.done));
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD > 0 ? 200000 : 1) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && !done, "R1 reset state", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!valid && !done, "R1 idle before load", int'(done), 0);

    // R2 R3 R4 sequential, every length
    issue(9'h000, 2'd0, 1'b0, 1'b0, 1'b0, 0, "R2 seq bl1"); idle_gap(2);
    issue(9'h0A5, 2'd1, 1'b0, 1'b0, 1'b0, 0, "R4 seq bl2"); idle_gap(2);
    issue(9'h1F6, 2'd2, 1'b0, 1'b0, 1'b0, 0, "R4 seq bl4 wrap"); idle_gap(2);
    issue(9'h12D, 2'd3, 1'b0, 1'b0, 1'b0, 0, "R4 seq bl8 wrap"); idle_gap(2);
    issue(9'h1FF, 2'd3, 1'b0, 1'b0, 1'b0, 0, "R4 seq bl8 top"); idle_gap(1);
    // R5 interleaved
    issue(9'h0A5, 2'd1, 1'b1, 1'b0, 1'b0, 0, "R5 ilv bl2"); idle_gap(1);
    issue(9'h036, 2'd2, 1'b1, 1'b0, 1'b0, 0, "R5 ilv bl4"); idle_gap(1);
    issue(9'h10B, 2'd3, 1'b1, 1'b0, 1'b0, 0, "R5 ilv bl8"); idle_gap(1);
    issue(9'h0F0, 2'd0, 1'b1, 1'b0, 1'b0, 0, "R5 ilv bl1"); idle_gap(1);
    // R6 single write
    issue(9'h055, 2'd3, 1'b0, 1'b1, 1'b1, 0, "R6 single write"); idle_gap(2);
    issue(9'h055, 2'd3, 1'b0, 1'b1, 1'b0, 0, "R6 read keeps bl8"); idle_gap(1);
    issue(9'h072, 2'd2, 1'b0, 1'b0, 1'b1, 0, "R6 write without single"); idle_gap(1);
    // R8 restart mid-burst, back-to-back
    issue(9'h010, 2'd3, 1'b0, 1'b0, 1'b0, 3, "R8 cut seq");
    issue(9'h1C7, 2'd3, 1'b1, 1'b0, 1'b0, 5, "R8 cut ilv");
    issue(9'h08E, 2'd2, 1'b0, 1'b0, 1'b0, 0, "R8 restart seq"); idle_gap(1);
    issue(9'h033, 2'd1, 1'b0, 1'b0, 1'b0, 0, "R3 back to back a");
    issue(9'h144, 2'd1, 1'b1, 1'b0, 1'b0, 0, "R3 back to back b"); idle_gap(3);

    chk(sb.size() == 0, "R3 all beats seen", sb.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule